// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

A purely combinational 32-bit shift unit for an integer datapath. One cycle after its inputs settle (zero cycles, in fact), it returns a shifted or rotated word and the bit that left the word last, ready to be written into a carry flag by the surrounding pipeline. Five operations are offered: arithmetic right shift, logical left shift, logical right shift, right rotation, and a one-position right rotation that threads the incoming carry into the top bit.

The distance can be taken from a full register word, of which only the bottom eight bits count (so distances run from 0 to 255), or from a short immediate field. Distances of the word width and beyond have fully defined results and carry, so the unit can be driven directly from register contents without any clamping upstream. Flag storage and instruction decode sit outside the block.

Top module: `bshift_unit`

## Requirements
- R1: When `use_reg` is 1 the distance is `reg_amt[7:0]` and bits above bit 7 have no effect; when `use_reg` is 0 the distance is `imm_amt` zero-extended.
- R2: For ASR, LSL, LSR and ROR with a distance of 0, `data_out` equals `data_in` and `carry_out` equals `carry_in`.
- R3: LSL (`op_sel`=1) with distance n in 1..31 gives `data_in << n`, and `carry_out` is `data_in[32-n]`.
- R4: LSR (`op_sel`=2) with distance n in 1..31 gives `data_in >> n` with zero fill, and `carry_out` is `data_in[n-1]`.
- R5: ASR (`op_sel`=0) with distance n in 1..31 fills vacated top bits with `data_in[31]`, and `carry_out` is `data_in[n-1]`.
- R6: ROR (`op_sel`=3) rotates right by the distance modulo 32, `carry_out` being the new bit 31; a nonzero multiple of 32 leaves the word unchanged with `carry_out` = `data_in[31]`.
- R7: LSL and LSR with distance 32 give zero with `carry_out` equal to `data_in[0]` (LSL) or `data_in[31]` (LSR); beyond 32 both result and carry are zero.
- R8: ASR with distance 32 or more sets every result bit and `carry_out` to `data_in[31]`.
- R9: RRX (`op_sel`=4) ignores the distance and returns `{carry_in, data_in[31:1]}` with `carry_out` = `data_in[0]`.
- R10: Codes 5, 6 and 7 of `op_sel` pass `data_in` through and return `carry_in` as `carry_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 32 | Word to shift or rotate |
| reg_amt | input | 32 | Register-sourced distance; only bits 7:0 are used |
| imm_amt | input | 6 | Immediate distance, 0 to 63 |
| use_reg | input | 1 | 1 selects `reg_amt`, 0 selects `imm_amt` |
| op_sel | input | 3 | 0 ASR, 1 LSL, 2 LSR, 3 ROR, 4 RRX, others pass |
| carry_in | input | 1 | Current carry flag |
| data_out | output | 32 | Shifted or rotated word |
| carry_out | output | 1 | Last bit shifted out, or `carry_in` when nothing moves |

## Verification
The embedded checks are immediate ones evaluated whenever the combinational logic settles, so they take for granted that every input is a known two-state value and that the inputs are not changing within the evaluation in which they are checked. The stimulus honours this by driving all inputs together, one millisecond-free nanosecond after a clock edge, and sampling only at the opposite edge, never during a change. The distance encodings the checks lean on (the low byte of the register, the zero-extended immediate, the op codes) are only ever driven with values the requirements define, including the unused codes of `op_sel`.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
   typedef enum logic [2:0] {
      OP_ASR = 3'd0,
      OP_LSL = 3'd1,
      OP_LSR = 3'd2,
      OP_ROR = 3'd3,
      OP_RRX = 3'd4
   } bsh_op_e;
endpackage

// File: rtl/bsh_amount.sv
module bsh_amount #(
   parameter int W     = 32,
   parameter int AMT_W = 8,
   parameter int IMM_W = 6
) (
   input  logic [W-1:0]     reg_amt,
   input  logic [IMM_W-1:0] imm_amt,
   input  logic             use_reg,
   output logic [AMT_W-1:0] amt
);
   generate
      if (AMT_W >= W) begin : g_bad_amt
         $error("bsh_amount: AMT_W must be narrower than W");
      end
      if (IMM_W > AMT_W) begin : g_bad_imm
         $error("bsh_amount: IMM_W must not exceed AMT_W");
      end
   endgenerate

   localparam int PAD_W = AMT_W - IMM_W;

   logic [AMT_W-1:0] imm_wide;

   generate
      if (PAD_W > 0) begin : g_pad
         assign imm_wide = {{PAD_W{1'b0}}, imm_amt};
      end else begin : g_nopad
         assign imm_wide = imm_amt;
      end
   endgenerate

   assign amt = use_reg ? reg_amt[AMT_W-1:0] : imm_wide;

   always_comb begin
      if (use_reg && (reg_amt[W-1:AMT_W] != '0)) begin
         p_low_byte_only_r1: assert (amt == reg_amt[AMT_W-1:0])
            else $error("R1: upper register bits leaked into distance");
      end
      if (!use_reg) begin
         p_imm_extend_r1: assert (amt[IMM_W-1:0] == imm_amt)
            else $error("R1: immediate distance mismatch");
      end
   end
endmodule

// File: rtl/bsh_bitrev.sv
module bsh_bitrev #(
   parameter int W = 32
) (
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign q[i] = d[W-1-i];
      end
   endgenerate
endmodule

// File: rtl/bsh_rotr.sv
module bsh_rotr #(
   parameter int W = 32,
   localparam int SH_W = $clog2(W)
) (
   input  logic [W-1:0]    d,
   input  logic [SH_W-1:0] sh,
   output logic [W-1:0]    q
);
   generate
      if ((1 << SH_W) != W) begin : g_bad_w
         $error("bsh_rotr: W must be a power of two");
      end
   endgenerate

   logic [W-1:0] stg [0:SH_W];

   assign stg[0] = d;

   generate
      for (genvar k = 0; k < SH_W; k++) begin : g_stage
         localparam int STEP = 1 << k;
         assign stg[k+1] = sh[k] ? {stg[k][STEP-1:0], stg[k][W-1:STEP]}
                                 : stg[k];
      end
   endgenerate

   assign q = stg[SH_W];

   always_comb begin
      p_rot_keeps_ones_r6: assert ($countones(q) == $countones(d))
         else $error("R6: rotator lost or gained bits");
   end
endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
   import bsh_pkg::*;
#(
   parameter int W     = 32,
   parameter int AMT_W = 8,
   parameter int IMM_W = 6
) (
   input  logic [W-1:0]     data_in,
   input  logic [W-1:0]     reg_amt,
   input  logic [IMM_W-1:0] imm_amt,
   input  logic             use_reg,
   input  logic [2:0]       op_sel,
   input  logic             carry_in,
   output logic [W-1:0]     data_out,
   output logic             carry_out
);
   localparam int SH_W = $clog2(W);

   generate
      if (AMT_W <= SH_W) begin : g_bad_amt
         $error("bshift_unit: AMT_W must reach the word width");
      end
   endgenerate

   bsh_op_e          op;
   logic [AMT_W-1:0] amt;
   logic [SH_W-1:0]  sh;
   logic             amt_zero;
   logic             amt_over;
   logic             amt_full;
   logic             sign;
   logic [W-1:0]     rev_in;
   logic [W-1:0]     rot_src;
   logic [W-1:0]     rotated;
   logic [W-1:0]     keep_mask;
   logic [W-1:0]     right_val;
   logic [W-1:0]     left_val;
   logic             edge_cy;

   assign op = bsh_op_e'(op_sel);

   bsh_amount #(.W(W), .AMT_W(AMT_W), .IMM_W(IMM_W)) u_amt (
      .reg_amt (reg_amt),
      .imm_amt (imm_amt),
      .use_reg (use_reg),
      .amt     (amt)
   );

   assign sh       = amt[SH_W-1:0];
   assign amt_zero = (amt == '0);
   assign amt_over = |amt[AMT_W-1:SH_W];
   assign amt_full = amt_over && (amt[AMT_W-1:SH_W] == 1) && (sh == '0);
   assign sign     = data_in[W-1];

   bsh_bitrev #(.W(W)) u_rev_in (
      .d (data_in),
      .q (rev_in)
   );

   assign rot_src = (op == OP_LSL) ? rev_in : data_in;

   bsh_rotr #(.W(W)) u_rot (
      .d  (rot_src),
      .sh (sh),
      .q  (rotated)
   );

   assign keep_mask = {W{1'b1}} >> sh;
   assign right_val = rotated & keep_mask;
   assign edge_cy   = rotated[W-1];

   bsh_bitrev #(.W(W)) u_rev_out (
      .d (right_val),
      .q (left_val)
   );

   always_comb begin
      data_out  = data_in;
      carry_out = carry_in;
      unique case (op)
         OP_ASR: begin
            if (amt_over) begin
               data_out  = {W{sign}};
               carry_out = sign;
            end else if (!amt_zero) begin
               data_out  = right_val | (~keep_mask & {W{sign}});
               carry_out = edge_cy;
            end
         end
         OP_LSL: begin
            if (amt_full) begin
               data_out  = '0;
               carry_out = data_in[0];
            end else if (amt_over) begin
               data_out  = '0;
               carry_out = 1'b0;
            end else if (!amt_zero) begin
               data_out  = left_val;
               carry_out = edge_cy;
            end
         end
         OP_LSR: begin
            if (amt_full) begin
               data_out  = '0;
               carry_out = sign;
            end else if (amt_over) begin
               data_out  = '0;
               carry_out = 1'b0;
            end else if (!amt_zero) begin
               data_out  = right_val;
               carry_out = edge_cy;
            end
         end
         OP_ROR: begin
            if (!amt_zero) begin
               data_out  = rotated;
               carry_out = edge_cy;
            end
         end
         OP_RRX: begin
            data_out  = {carry_in, data_in[W-1:1]};
            carry_out = data_in[0];
         end
         default: begin
            data_out  = data_in;
            carry_out = carry_in;
         end
      endcase
   end

   always_comb begin
      if (amt_zero && (op_sel < 3'd4)) begin
         p_zero_dist_pass_r2: assert ((data_out == data_in) && (carry_out == carry_in))
            else $error("R2: zero distance altered the word or carry");
      end
      if ((op == OP_LSR) && !amt_zero) begin
         p_lsr_top_clear_r4: assert (data_out[W-1] == 1'b0)
            else $error("R4: logical right shift left a top bit set");
      end
      if (op == OP_ASR) begin
         p_asr_keeps_sign_r5: assert (data_out[W-1] == data_in[W-1])
            else $error("R5: arithmetic shift changed the sign bit");
      end
      if (((op == OP_LSL) || (op == OP_LSR)) && amt_over) begin
         p_long_shift_zero_r7: assert (data_out == '0)
            else $error("R7: long logical shift not zero");
      end
      if (op == OP_RRX) begin
         p_rrx_thread_r9: assert ((data_out[W-1] == carry_in) && (carry_out == data_in[0]))
            else $error("R9: carry not threaded through rotation");
      end
   end
endmodule

// File: tb/sim_bshift_unit.sv
module sim_bshift_unit;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst;
   logic [31:0] data_in;
   logic [31:0] reg_amt;
   logic [5:0]  imm_amt;
   logic        use_reg;
   logic [2:0]  op_sel;
   logic        carry_in;
   logic [31:0] data_out;
   logic        carry_out;

   bshift_unit u0 (
      .data_in   (data_in),
      .reg_amt   (reg_amt),
      .imm_amt   (imm_amt),
      .use_reg   (use_reg),
      .op_sel    (op_sel),
      .carry_in  (carry_in),
      .data_out  (data_out),
      .carry_out (carry_out)
   );

   typedef struct {
      logic [31:0] exp_val;
      logic        exp_cy;
      string       tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // Bit-at-a-time reference built from the requirement text.
   task automatic ref_model(input logic [31:0] d, input int n, input logic [2:0] op,
                            input logic ci, output logic [31:0] r, output logic c);
      r = d;
      c = ci;
      case (op)
         3'd0: for (int i = 0; i < n; i++) begin c = r[0]; r = {r[31], r[31:1]}; end
         3'd1: for (int i = 0; i < n; i++) begin c = r[31]; r = {r[30:0], 1'b0}; end
         3'd2: for (int i = 0; i < n; i++) begin c = r[0]; r = {1'b0, r[31:1]}; end
         3'd3: for (int i = 0; i < n; i++) begin c = r[0]; r = {r[0], r[31:1]}; end
         3'd4: begin c = d[0]; r = {ci, d[31:1]}; end
         default: ;
      endcase
   endtask

   task automatic drive(input logic [31:0] d, input logic [31:0] ra, input logic [5:0] ia,
                        input logic ur, input logic [2:0] op, input logic ci, input string tag);
      sb_item_t it;
      int n;
      @(posedge clk);
      #1;
      data_in  = d;
      reg_amt  = ra;
      imm_amt  = ia;
      use_reg  = ur;
      op_sel   = op;
      carry_in = ci;
      n = ur ? int'(ra[7:0]) : int'(ia);
      ref_model(d, n, op, ci, it.exp_val, it.exp_cy);
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   always @(negedge clk) begin
      if (!rst && sb_q.size() > 0) begin
         sb_item_t it;
         it = sb_q.pop_front();
         total++;
         if (data_out !== it.exp_val || carry_out !== it.exp_cy) begin
            bad++;
            $display("FAIL %s: got data=%h cy=%b expected data=%h cy=%b",
                     it.tag, data_out, carry_out, it.exp_val, it.exp_cy);
         end
      end
   end

   function automatic string op_tag(input logic [2:0] op);
      case (op)
         3'd0: return "R5";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R6";
         3'd4: return "R9";
         default: return "R10";
      endcase
   endfunction

   initial begin
      rst = 1'b1;
      data_in = '0; reg_amt = '0; imm_amt = '0; use_reg = 1'b0; op_sel = '0; carry_in = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset state: all-zero inputs give zero word and zero carry (R2)
      drive(32'h0, 32'h0, 6'd0, 1'b0, 3'd0, 1'b0, "R2 idle");
      // R1 register low byte, upper bits junk; immediate path with junk register
      drive(32'hF000_00F0, 32'hFFFF_FF04, 6'd63, 1'b1, 3'd2, 1'b0, "R1 reg low byte");
      drive(32'hF000_00F0, 32'hABCD_EF00, 6'd4, 1'b0, 3'd2, 1'b0, "R1 imm source");
      drive(32'h8000_0001, 32'h0000_0100, 6'd9, 1'b1, 3'd1, 1'b1, "R1 reg byte zero");
      // R2 zero distance for each shift op
      for (int o = 0; o < 4; o++)
         drive(32'hDEAD_BEEF, 32'h0, 6'd0, 1'b0, 3'(o), 1'b1, "R2 zero distance");
      // R3
      drive(32'h8000_0001, 32'h0, 6'd1, 1'b0, 3'd1, 1'b0, "R3 lsl 1");
      drive(32'h0000_0003, 32'h0, 6'd31, 1'b0, 3'd1, 1'b0, "R3 lsl 31");
      // R4
      drive(32'h8000_0001, 32'h0, 6'd1, 1'b0, 3'd2, 1'b0, "R4 lsr 1");
      drive(32'hC000_0000, 32'h1F, 6'd0, 1'b1, 3'd2, 1'b1, "R4 lsr 31");
      // R5
      drive(32'h8000_0010, 32'h0, 6'd4, 1'b0, 3'd0, 1'b0, "R5 asr neg");
      drive(32'h7000_0008, 32'h0, 6'd4, 1'b0, 3'd0, 1'b1, "R5 asr pos");
      // R6
      drive(32'h1234_5678, 32'h0, 6'd8, 1'b0, 3'd3, 1'b0, "R6 ror 8");
      drive(32'h1234_5678, 32'd40, 6'd0, 1'b1, 3'd3, 1'b0, "R6 ror 40");
      drive(32'h8765_4321, 32'd32, 6'd0, 1'b1, 3'd3, 1'b0, "R6 ror 32");
      drive(32'h0765_4321, 32'd64, 6'd0, 1'b1, 3'd3, 1'b1, "R6 ror 64");
      // R7
      drive(32'h0000_0001, 32'h0, 6'd32, 1'b0, 3'd1, 1'b0, "R7 lsl 32");
      drive(32'h8000_0000, 32'h0, 6'd32, 1'b0, 3'd2, 1'b0, "R7 lsr 32");
      drive(32'hFFFF_FFFF, 32'h0, 6'd33, 1'b0, 3'd1, 1'b1, "R7 lsl 33");
      drive(32'hFFFF_FFFF, 32'd255, 6'd0, 1'b1, 3'd2, 1'b1, "R7 lsr 255");
      // R8
      drive(32'h8000_0000, 32'h0, 6'd32, 1'b0, 3'd0, 1'b0, "R8 asr 32 neg");
      drive(32'h7FFF_FFFF, 32'd200, 6'd0, 1'b1, 3'd0, 1'b1, "R8 asr 200 pos");
      // R9
      drive(32'h0000_0003, 32'd17, 6'd5, 1'b1, 3'd4, 1'b1, "R9 rrx carry set");
      drive(32'h8000_0002, 32'h0, 6'd0, 1'b0, 3'd4, 1'b0, "R9 rrx carry clear");
      // R10
      for (int o = 5; o < 8; o++)
         drive(32'hCAFE_F00D, 32'd3, 6'd3, 1'b0, 3'(o), 1'b1, "R10 spare code");
      // mixed patterns
      for (int i = 0; i < 400; i++) begin
         logic [2:0] op;
         op = 3'($urandom_range(0, 7));
         drive($urandom, $urandom, 6'($urandom), 1'($urandom), op, 1'($urandom), op_tag(op));
      end
      repeat (3) @(posedge clk);
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule